// File: doc/BRIEF.md
# SDRAM Command Sequencer

This controller drives the command pins of an SDRAM device, working alongside a separate datapath that holds the address, data and read-buffer registers. It starts with the power-up sequence:

- a long wait with NOP on the pins;
- a precharge of every bank;
- a parameterised number of auto-refresh cycles;
- a load-mode-register command.

It holds an init-busy flag high for the whole sequence. Once the sequence is done, it idles and serves the datapath. The datapath asks for a single-word write or a four-word burst read by holding a request level. The sequencer answers with one ACTIVATE, then the READ or WRITE, then a precharge of all banks. It also slots in an auto-refresh whenever the refresh interval has run out.

The sequencer never drives address bits itself. It tells the datapath what to put on the pins through two 2-bit select codes: one for the main address bits and one for pin A10 alone.

It answers requests with single-cycle acknowledge pulses. On a read it also raises a data-capture strobe for exactly four clocks, lined up with the burst arriving on the DQ bus. All timing values are module parameters counted in memory clocks. The mode value that the datapath programs must carry the same CAS latency as the `CAS_LAT` parameter, so that the strobe lines up with the data.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is held, the command pins show NOP, `init_busy` is 1, and all acknowledges and `rd_strobe` are 0.
- R2: After reset, cycle 0 is the first cycle with reset low. PRECHARGE comes in cycle T_INIT with `a10_sel`=11 (A10 forced high, all banks). The first AUTO REFRESH follows T_RP cycles later, and each further one of the INIT_REFS refreshes follows T_RFC cycles after the previous one.
- R3: LOAD MODE comes T_RFC cycles after the last init refresh, with `addr_sel`=10 (mode value) and `a10_sel`=10 (mode bit 10). `mset_ack` pulses in that cycle only and only once. `init_busy` falls T_MRD cycles after LOAD MODE.
- R4: While `init_busy` is high, a raised request produces no ACTIVE, READ or WRITE.
- R5: A request seen in an idle cycle with no refresh pending produces ACTIVE in the next cycle, with `addr_sel`=00 (row) and `a10_sel`=00 (row bit 10). A read request wins over a write request.
- R6: READ or WRITE comes T_RCD cycles after ACTIVE, with `addr_sel`=01 (column) and `a10_sel`=01 (A10 low, no auto-precharge). `rd_ack` pulses exactly in READ cycles and `wr_ack` exactly in WRITE cycles.
- R7: The precharge that closes an access has `a10_sel`=11. It follows a READ by max(CAS_LAT+4, T_RAS-T_RCD, 2) cycles and a WRITE by max(T_WR, T_RAS-T_RCD, 2) cycles. No command other than NOP comes within T_RP cycles after it.
- R8: `rd_strobe` rises CAS_LAT cycles after each READ and stays high for exactly 4 consecutive cycles.
- R9: Refresh-due events come every T_REFI cycles, counted from the first idle cycle. An idle sequencer issues AUTO REFRESH two cycles after each event, so consecutive periodic refreshes are T_REFI cycles apart.
- R10: A pending refresh is served before a request present in the same idle cycle. The request's ACTIVE then follows T_RFC+1 cycles after the refresh.
- R11: Pins {cs_n,ras_n,cas_n,we_n} only take the following values:

  | Command | Pin value |
  |---|---|
  | NOP | 0111 |
  | ACTIVE | 0011 |
  | READ | 0101 |
  | WRITE | 0100 |
  | PRECHARGE | 0010 |
  | AUTO REFRESH | 0001 |
  | LOAD MODE | 0000 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_req | input | 1 | Burst read request level from the datapath |
| wr_req | input | 1 | Single-word write request level from the datapath |
| init_busy | output | 1 | High during the power-up sequence |
| rd_ack | output | 1 | One-cycle pulse when READ is issued |
| wr_ack | output | 1 | One-cycle pulse when WRITE is issued |
| mset_ack | output | 1 | One-cycle pulse when LOAD MODE is issued |
| rd_strobe | output | 1 | Read data capture strobe, four cycles per burst |
| cs_n | output | 1 | SDRAM chip select, active low |
| ras_n | output | 1 | SDRAM row strobe, active low |
| cas_n | output | 1 | SDRAM column strobe, active low |
| we_n | output | 1 | SDRAM write enable, active low |
| addr_sel | output | 2 | Address source: 00 row, 01 column, 10 mode value, 11 zero |
| a10_sel | output | 2 | A10 source: 00 row bit, 01 low, 10 mode bit, 11 high |

## Verification
Every command and pulse comes straight from the state register, so each result is due a fixed number of cycles after the cycle that decided it. ACTIVE is due one cycle after a request is seen idle. READ or WRITE is due T_RCD after ACTIVE, the closing precharge is due after the access spacing, and the strobe is due CAS_LAT after READ. The init commands are due at the sums of T_INIT, T_RP, T_RFC and T_MRD. The bench keeps one cycle counter and samples between clock edges. A monitor stamps each decoded command with the cycle it appeared in. The checks then compare stamp differences with the values listed above, rather than waiting a guessed number of cycles.

// File: rtl/sdseq_pkg.sv
`timescale 1ns/1ps
package sdseq_pkg;

  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_t;

  localparam logic [1:0] ASEL_ROW  = 2'b00;
  localparam logic [1:0] ASEL_COL  = 2'b01;
  localparam logic [1:0] ASEL_MODE = 2'b10;
  localparam logic [1:0] ASEL_ZERO = 2'b11;

  localparam logic [1:0] A10_ROW   = 2'b00;
  localparam logic [1:0] A10_LOW   = 2'b01;
  localparam logic [1:0] A10_MODE  = 2'b10;
  localparam logic [1:0] A10_HIGH  = 2'b11;

  typedef enum logic [4:0] {
    ST_INIT_WAIT, ST_INIT_PRE, ST_INIT_PRE_W, ST_INIT_REF, ST_INIT_REF_W,
    ST_INIT_LMR, ST_INIT_LMR_W, ST_IDLE, ST_REF, ST_REF_W, ST_ACT,
    ST_ACT_W, ST_RD, ST_WR, ST_ACC_W, ST_PRE, ST_PRE_W
  } seq_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // READ to closing precharge: burst must drain and tRAS must be met
  function automatic int rd_close_gap(input int cl, input int burst,
                                      input int ras, input int rcd);
    return max2(max2(cl + burst, ras - rcd), 2);
  endfunction

  // WRITE to closing precharge: write recovery and tRAS
  function automatic int wr_close_gap(input int wr, input int ras, input int rcd);
    return max2(max2(wr, ras - rcd), 2);
  endfunction

endpackage

// File: rtl/sdseq_wait_timer.sv
`timescale 1ns/1ps
module sdseq_wait_timer #(
  parameter int W         = 8,
  parameter int RESET_VAL = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= W'(RESET_VAL);
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  // the current wait cycle is the last one
  assign done = (cnt_q <= W'(1));
endmodule

// File: rtl/sdseq_refresh_timer.sv
`timescale 1ns/1ps
module sdseq_refresh_timer #(
  parameter int T_REFI = 780
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic tick,
  output logic pending
);
  localparam int CW = (T_REFI > 1) ? $clog2(T_REFI) : 1;

  logic [CW-1:0] cnt_q;
  logic          pend_q;

  assign tick = run && (cnt_q == CW'(T_REFI - 1));

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= '0;
    else if (run)
      cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      pend_q <= 1'b0;
    else if (tick)
      pend_q <= 1'b1;
    else if (clear)
      pend_q <= 1'b0;
  end

  assign pending = pend_q;
endmodule

// File: rtl/sdseq_burst_strobe.sv
`timescale 1ns/1ps
module sdseq_burst_strobe #(
  parameter int CAS_LAT = 2,
  parameter int BURST   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  output logic strobe
);
  localparam int BW = $clog2(BURST + 1);

  logic [CAS_LAT-1:0] pipe_q;
  logic [BW-1:0]      left_q;
  logic               tail;

  generate
    if (CAS_LAT == 1) begin : g_lat1
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= launch;
      end
    end else begin : g_latn
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[CAS_LAT-2:0], launch};
      end
    end
  endgenerate

  assign tail = pipe_q[CAS_LAT-1];

  always_ff @(posedge clk) begin
    if (rst)
      left_q <= '0;
    else if (tail)
      left_q <= BW'(BURST - 1);
    else if (left_q != '0)
      left_q <= left_q - 1'b1;
  end

  assign strobe = tail || (left_q != '0);
endmodule

// File: rtl/sdram_cmd_seq.sv
`timescale 1ns/1ps
module sdram_cmd_seq
  import sdseq_pkg::*;
#(
  parameter int T_INIT    = 200,
  parameter int T_RP      = 2,
  parameter int T_RFC     = 7,
  parameter int T_MRD     = 2,
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 5,
  parameter int T_WR      = 2,
  parameter int CAS_LAT   = 2,
  parameter int T_REFI    = 780,
  parameter int INIT_REFS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_req,
  input  logic       wr_req,
  output logic       init_busy,
  output logic       rd_ack,
  output logic       wr_ack,
  output logic       mset_ack,
  output logic       rd_strobe,
  output logic       cs_n,
  output logic       ras_n,
  output logic       cas_n,
  output logic       we_n,
  output logic [1:0] addr_sel,
  output logic [1:0] a10_sel
);
  localparam int BURST  = 4;
  localparam int RD_GAP = rd_close_gap(CAS_LAT, BURST, T_RAS, T_RCD);
  localparam int WR_GAP = wr_close_gap(T_WR, T_RAS, T_RCD);
  localparam int MAXT   = max2(max2(max2(T_INIT, T_RFC), max2(RD_GAP, WR_GAP)),
                               max2(max2(T_RP, T_MRD), T_RCD));
  localparam int TW     = $clog2(MAXT + 1);
  localparam int RCW    = $clog2(INIT_REFS + 1);

  seq_state_t     state_q, state_d;
  logic           op_rd_q, op_rd_d;
  logic [RCW-1:0] refs_q;
  logic           tmr_load;
  logic [TW-1:0]  tmr_val;
  logic           tmr_done;
  sd_cmd_t        cmd_w;

  // named internal events, also used by the checker
  logic idle_w;
  logic ref_pending_w;
  logic ref_tick_w;
  logic ref_issue_w;
  logic rd_issue_w;

  assign idle_w      = (state_q == ST_IDLE);
  assign ref_issue_w = (state_q == ST_REF);
  assign rd_issue_w  = (state_q == ST_RD);

  sdseq_wait_timer #(.W(TW), .RESET_VAL(T_INIT)) u_wait (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  sdseq_refresh_timer #(.T_REFI(T_REFI)) u_refi (
    .clk(clk), .rst(rst), .run(!init_busy), .clear(ref_issue_w),
    .tick(ref_tick_w), .pending(ref_pending_w)
  );

  sdseq_burst_strobe #(.CAS_LAT(CAS_LAT), .BURST(BURST)) u_strobe (
    .clk(clk), .rst(rst), .launch(rd_issue_w), .strobe(rd_strobe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_INIT_WAIT;
      op_rd_q <= 1'b0;
      refs_q  <= '0;
    end else begin
      state_q <= state_d;
      op_rd_q <= op_rd_d;
      if (state_q == ST_INIT_REF)
        refs_q <= refs_q + 1'b1;
    end
  end

  // next state and wait-timer loading
  always_comb begin
    state_d  = state_q;
    op_rd_d  = op_rd_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_INIT_WAIT:  if (tmr_done) state_d = ST_INIT_PRE;
      ST_INIT_PRE: begin
        state_d = ST_INIT_PRE_W; tmr_load = 1'b1; tmr_val = TW'(T_RP - 1);
      end
      ST_INIT_PRE_W: if (tmr_done) state_d = ST_INIT_REF;
      ST_INIT_REF: begin
        state_d = ST_INIT_REF_W; tmr_load = 1'b1; tmr_val = TW'(T_RFC - 1);
      end
      ST_INIT_REF_W:
        if (tmr_done)
          state_d = (refs_q == RCW'(INIT_REFS)) ? ST_INIT_LMR : ST_INIT_REF;
      ST_INIT_LMR: begin
        state_d = ST_INIT_LMR_W; tmr_load = 1'b1; tmr_val = TW'(T_MRD - 1);
      end
      ST_INIT_LMR_W: if (tmr_done) state_d = ST_IDLE;
      ST_IDLE: begin
        if (ref_pending_w) begin
          state_d = ST_REF;
        end else if (rd_req) begin
          state_d = ST_ACT; op_rd_d = 1'b1;
        end else if (wr_req) begin
          state_d = ST_ACT; op_rd_d = 1'b0;
        end
      end
      ST_REF: begin
        state_d = ST_REF_W; tmr_load = 1'b1; tmr_val = TW'(T_RFC - 1);
      end
      ST_REF_W: if (tmr_done) state_d = ST_IDLE;
      ST_ACT: begin
        state_d = ST_ACT_W; tmr_load = 1'b1; tmr_val = TW'(T_RCD - 1);
      end
      ST_ACT_W: if (tmr_done) state_d = op_rd_q ? ST_RD : ST_WR;
      ST_RD: begin
        state_d = ST_ACC_W; tmr_load = 1'b1; tmr_val = TW'(RD_GAP - 1);
      end
      ST_WR: begin
        state_d = ST_ACC_W; tmr_load = 1'b1; tmr_val = TW'(WR_GAP - 1);
      end
      ST_ACC_W: if (tmr_done) state_d = ST_PRE;
      ST_PRE: begin
        state_d = ST_PRE_W; tmr_load = 1'b1; tmr_val = TW'(T_RP - 1);
      end
      ST_PRE_W: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_INIT_WAIT;
    endcase
  end

  // command pins and address selects decoded from the state
  always_comb begin
    cmd_w    = CMD_NOP;
    addr_sel = ASEL_ZERO;
    a10_sel  = A10_LOW;
    case (state_q)
      ST_INIT_PRE, ST_PRE: begin
        cmd_w = CMD_PRE; a10_sel = A10_HIGH;
      end
      ST_INIT_REF, ST_REF: cmd_w = CMD_REF;
      ST_INIT_LMR: begin
        cmd_w = CMD_LMR; addr_sel = ASEL_MODE; a10_sel = A10_MODE;
      end
      ST_ACT: begin
        cmd_w = CMD_ACT; addr_sel = ASEL_ROW; a10_sel = A10_ROW;
      end
      ST_RD: begin
        cmd_w = CMD_RD; addr_sel = ASEL_COL; a10_sel = A10_LOW;
      end
      ST_WR: begin
        cmd_w = CMD_WR; addr_sel = ASEL_COL; a10_sel = A10_LOW;
      end
      default: ;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_w;

  assign init_busy = (state_q == ST_INIT_WAIT) || (state_q == ST_INIT_PRE) ||
                     (state_q == ST_INIT_PRE_W) || (state_q == ST_INIT_REF) ||
                     (state_q == ST_INIT_REF_W) || (state_q == ST_INIT_LMR) ||
                     (state_q == ST_INIT_LMR_W);
  assign rd_ack   = rd_issue_w;
  assign wr_ack   = (state_q == ST_WR);
  assign mset_ack = (state_q == ST_INIT_LMR);
endmodule

// File: rtl/sdseq_checker.sv
`timescale 1ns/1ps
module sdseq_checker #(
  parameter int BURST = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       init_busy,
  input logic       rd_ack,
  input logic       wr_ack,
  input logic       mset_ack,
  input logic       rd_strobe,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [1:0] addr_sel,
  input logic [1:0] a10_sel,
  input logic       idle_w,
  input logic       ref_pending_w,
  input logic       ref_tick_w
);
  localparam int RW = $clog2(BURST + 2);
  logic [3:0]    pins;
  logic [RW-1:0] run_q;

  assign pins = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk) begin
    if (rst)            run_q <= '0;
    else if (rd_strobe) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  a_r6_acks_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_ack, wr_ack, mset_ack}));

  a_r6_rd_ack_read: assert property (@(posedge clk) disable iff (rst)
    rd_ack |-> (pins == 4'b0101 && addr_sel == 2'b01 && a10_sel == 2'b01));

  a_r6_wr_ack_write: assert property (@(posedge clk) disable iff (rst)
    wr_ack |-> (pins == 4'b0100 && addr_sel == 2'b01 && a10_sel == 2'b01));

  a_r3_mset_lmr: assert property (@(posedge clk) disable iff (rst)
    mset_ack |-> (pins == 4'b0000 && init_busy && addr_sel == 2'b10 && a10_sel == 2'b10));

  a_r4_no_access_init: assert property (@(posedge clk) disable iff (rst)
    init_busy |-> (pins != 4'b0011 && pins != 4'b0101 && pins != 4'b0100));

  a_r5_act_row: assert property (@(posedge clk) disable iff (rst)
    (pins == 4'b0011) |-> (addr_sel == 2'b00 && a10_sel == 2'b00));

  a_r7_pre_all: assert property (@(posedge clk) disable iff (rst)
    (pins == 4'b0010) |-> (a10_sel == 2'b11));

  a_r8_strobe_max: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |-> (run_q < RW'(BURST)));

  a_r8_strobe_full: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_strobe) |-> (run_q == RW'(BURST)));

  a_r9_tick_pending: assert property (@(posedge clk) disable iff (rst)
    ref_tick_w |=> ref_pending_w);

  a_r10_ref_first: assert property (@(posedge clk) disable iff (rst)
    (idle_w && ref_pending_w) |=> (pins == 4'b0001));
endmodule

bind sdram_cmd_seq sdseq_checker #(.BURST(4)) u_sdseq_checker (
  .clk(clk), .rst(rst), .init_busy(init_busy), .rd_ack(rd_ack), .wr_ack(wr_ack),
  .mset_ack(mset_ack), .rd_strobe(rd_strobe), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .addr_sel(addr_sel), .a10_sel(a10_sel),
  .idle_w(idle_w), .ref_pending_w(ref_pending_w), .ref_tick_w(ref_tick_w)
);

// File: tb/test_sdram_cmd_seq.sv
`timescale 1ns/1ps
module test_sdram_cmd_seq;
  localparam int TI = 10, TP = 2, TF = 4, TM = 2, TRCD = 2, TRAS = 5, TWR = 2;
  localparam int CL = 2, REFI = 200;
  localparam int E  = TI + TP + 2*TF + TM;          // first idle cycle
  localparam int RD_SP0 = (CL + 4 > TRAS - TRCD) ? CL + 4 : TRAS - TRCD;
  localparam int RD_SP  = (RD_SP0 < 2) ? 2 : RD_SP0;
  localparam int WR_SP0 = (TWR > TRAS - TRCD) ? TWR : TRAS - TRCD;
  localparam int WR_SP  = (WR_SP0 < 2) ? 2 : WR_SP0;
  localparam int LIMIT  = 5000;

  // vector: {is_read, idle gap before request}
  localparam logic [3:0] ACC_TBL [0:5] = '{4'b1_000, 4'b0_011, 4'b1_001,
                                           4'b1_000, 4'b0_000, 4'b1_010};

  logic clk = 1'b0, rst = 1'b1, rd_req = 1'b0, wr_req = 1'b0;
  logic init_busy, rd_ack, wr_ack, mset_ack, rd_strobe;
  logic cs_n, ras_n, cas_n, we_n;
  logic [1:0] addr_sel, a10_sel;

  always #4 clk = ~clk;

  sdram_cmd_seq #(.T_INIT(TI), .T_RP(TP), .T_RFC(TF), .T_MRD(TM), .T_RCD(TRCD),
                  .T_RAS(TRAS), .T_WR(TWR), .CAS_LAT(CL), .T_REFI(REFI),
                  .INIT_REFS(2)) i_sdram_cmd_seq (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req), .init_busy(init_busy),
    .rd_ack(rd_ack), .wr_ack(wr_ack), .mset_ack(mset_ack), .rd_strobe(rd_strobe),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr_sel(addr_sel), .a10_sel(a10_sel));

  int checks = 0, errors = 0, cyc = 0;
  int t_act = 0, t_op = 0, t_pre = 0, pre_n = 0, pre_first = -1, t_mrs = -1;
  int ref_n = 0, mset_n = 0, bad_cmd = 0, ack_bad = 0, sel_bad = 0;
  int act_in_init = 0, strb_first = 0, strb_last = 0, strb_n = 0, quiet_bad = 0;
  int ref_t [0:7];
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  always @(posedge clk) begin
    if (rst) cyc <= 0; else cyc <= cyc + 1;
  end

  // command monitor, stamps every command with its cycle
  always @(negedge clk) begin
    if (!rst) begin
      case ({cs_n, ras_n, cas_n, we_n})
        4'b0111: ;
        4'b0011: begin
          t_act = cyc;
          if (init_busy) act_in_init++;
          if (addr_sel != 2'b00 || a10_sel != 2'b00) sel_bad++;
          if (pre_n > 0 && cyc - t_pre < TP) quiet_bad++;
        end
        4'b0101, 4'b0100: begin
          t_op = cyc; strb_n = 0;
          if (init_busy) act_in_init++;
          if (addr_sel != 2'b01 || a10_sel != 2'b01) sel_bad++;
        end
        4'b0010: begin
          if (pre_first < 0) pre_first = cyc; else begin t_pre = cyc; pre_n++; end
          if (a10_sel != 2'b11) sel_bad++;
        end
        4'b0001: begin
          if (ref_n < 8) ref_t[ref_n] = cyc;
          ref_n++;
          if (pre_n > 0 && cyc - t_pre < TP) quiet_bad++;
        end
        4'b0000: begin
          t_mrs = cyc;
          if (addr_sel != 2'b10 || a10_sel != 2'b10) sel_bad++;
        end
        default: bad_cmd++;
      endcase
      if (rd_ack != ({cs_n, ras_n, cas_n, we_n} == 4'b0101)) ack_bad++;
      if (wr_ack != ({cs_n, ras_n, cas_n, we_n} == 4'b0100)) ack_bad++;
      if (mset_ack) begin
        mset_n++;
        if ({cs_n, ras_n, cas_n, we_n} != 4'b0000) ack_bad++;
      end
      if (rd_strobe) begin
        if (strb_n == 0) strb_first = cyc;
        strb_last = cyc; strb_n++;
      end
    end
  end

  always @(posedge clk) begin
    if (!done && cyc > LIMIT) begin
      errors++;
      $display("FAIL watchdog (R1..R11 run) actual %0d expected below %0d", cyc, LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // one access; gap idle cycles first, then request held until ack
  task automatic do_access(input bit is_rd, input int gap);
    int t_req, pre_before;
    repeat (gap) tick();
    t_req = cyc; pre_before = pre_n;
    if (is_rd) rd_req = 1'b1; else wr_req = 1'b1;
    while (!(rd_ack || wr_ack)) tick();
    rd_req = 1'b0; wr_req = 1'b0;
    while (pre_n == pre_before) tick();
    repeat (TP) tick();
    chk("R5 act latency", t_act - t_req, 1);
    chk("R6 tRCD", t_op - t_act, TRCD);
    chk("R7 close gap", t_pre - t_op, is_rd ? RD_SP : WR_SP);
    if (is_rd) begin
      chk("R8 strobe offset", strb_first - t_op, CL);
      chk("R8 strobe count", strb_n, 4);
      chk("R8 strobe contiguous", strb_last - strb_first, 3);
    end
  endtask

  initial begin
    wr_req = 1'b1;                       // held through init (R4)
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 reset pins", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk("R1 reset busy", init_busy, 1);
    chk("R1 reset acks", {rd_ack, wr_ack, mset_ack, rd_strobe}, 0);
    rst = 1'b0;
    while (cyc < E - 1) tick();
    chk("R3 busy before end", init_busy, 1);
    tick();
    chk("R3 busy cleared", init_busy, 0);
    chk("R2 precharge time", pre_first, TI);
    chk("R2 refresh1 time", ref_t[0], TI + TP);
    chk("R2 refresh2 time", ref_t[1], TI + TP + TF);
    chk("R3 load mode time", t_mrs, TI + TP + 2*TF);
    chk("R3 mset pulses", mset_n, 1);
    // R4: write held since reset gets ACTIVE only after init
    while (!wr_ack) tick();
    wr_req = 1'b0;
    chk("R4 first act", t_act, E + 1);
    chk("R4 no access in init", act_in_init, 0);
    while (pre_n == 0) tick();
    repeat (TP) tick();
    chk("R7 write close gap", t_pre - t_op, WR_SP);

    for (int i = 0; i < 6; i++)
      do_access(ACC_TBL[i][3], int'(ACC_TBL[i][2:0]));

    // R5: read wins over write in the same cycle
    rd_req = 1'b1; wr_req = 1'b1;
    while (!(rd_ack || wr_ack)) tick();
    chk("R5 read priority", rd_ack, 1);
    rd_req = 1'b0; wr_req = 1'b0;
    repeat (RD_SP + TP + 2) tick();

    // R10: refresh pending meets a read request
    while (cyc < E + REFI) tick();
    rd_req = 1'b1;
    while (!rd_ack) tick();
    rd_req = 1'b0;
    chk("R9 first periodic refresh", ref_t[2], E + REFI + 1);
    chk("R10 act after refresh", t_act - ref_t[2], TF + 1);
    while (cyc < E + 2*REFI + 4) tick();
    chk("R9 refresh interval", ref_t[3] - ref_t[2], REFI);
    chk("R11 encodings", bad_cmd, 0);
    chk("R6 ack pulses", ack_bad, 0);
    chk("R7 selects", sel_bad, 0);
    chk("R7 quiet after pre", quiet_bad, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule